// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block sits next to a small processor core and decides which exception the core should enter next. It watches up to 32 peripheral request lines and three system sources: a non-maskable request, a fault request and a periodic tick. Each cycle it picks the most urgent pending and enabled source. If that source outranks the execution priority the core is running at, and no mask blocks it, the block offers the source's exception number and the address of its handler slot in a relocatable vector table.

The core takes an offer by pulsing `take_ack`. That clears the pending bit of the source, marks it active and raises the execution level. When the handler finishes, the core pulses `ret_req`. This retires the most urgent active exception and drops the execution level to the next active one. Software configures the block through a simple write/read register port. The port sets and clears enables and pending bits, programs 2-bit levels, moves the table base and sets a priority threshold below which programmable sources are held off.

Top module: `irq_prio_arbiter`

## Requirements
- R1: `take_valid` is high only when the selected source's encoded level is numerically below `cur_level` and no mask blocks it. An equal level never preempts.
- R2: Peripheral and tick levels are 2-bit values, where a lower value is more urgent. The encoded level is the value plus 2. When levels tie, the source with the lower exception number wins.
- R3: The non-maskable source has the fixed encoded level 0 and the fault source has the fixed encoded level 1. Both outrank every programmable level, and the non-maskable source outranks the fault.
- R4: `take_excnum` is 2 for the non-maskable source, 3 for the fault, 15 for the tick and 16+n for peripheral line n.
- R5: `take_vector` equals the table base plus 4 times `take_excnum`, so peripheral n sits at base + 0x40 + 4n.
- R6: The table base is written at register address 7. Bits [6:0] always read and act as zero, and the reset value is 0.
- R7: The threshold register at address 8 holds off every tick or peripheral request whose 2-bit level is greater than or equal to the threshold. A threshold of 0 disables the mask, and the mask never holds off the non-maskable or fault sources.
- R8: A level write goes to address 6, with the line index in wdata[15:8] and the level in wdata[1:0]. It is ignored while that line is enabled and takes effect while the line is disabled. The tick level is written at address 9.
- R9: A pending bit is set by a rising edge on its line, or for peripherals by a write of ones to address 2. It is cleared by acceptance, or for peripherals by a write of ones to address 3. Only lines enabled through address 0 (set) and address 1 (clear) take part in arbitration, while the system sources are always enabled.
- R10: Acceptance sets the source active. `cur_level` is the encoded level of the most urgent active source, or 255 when none is active. `ret_req` retires the most urgent active source and restores the next level.
- R11: After reset nothing is enabled, pending or active, `cur_level` is 255, `take_valid` is low and the table base and threshold read 0. Read addresses are: 0 for enables, 2 for pending, 4 for active, 7 for the table base, 8 for the threshold and 9 for the tick level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | NUM_IRQ | Peripheral request lines, rising-edge sensitive |
| nmi_req | input | 1 | Non-maskable request line |
| fault_req | input | 1 | Fault request line |
| tick_req | input | 1 | Periodic tick request line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| take_valid | output | 1 | An exception may preempt now |
| take_excnum | output | 8 | Exception number of the offered source |
| take_vector | output | ADDR_W | Handler slot address of the offered source |
| take_ack | input | 1 | Core accepts the offered exception |
| ret_req | input | 1 | Core returns from the current handler |
| cur_level | output | 8 | Encoded current execution level, 255 when idle |

## Verification
The bench targets equal-level cases. A source at the same level as the running handler must wait, which catches a design that uses a non-strict compare and re-enters at the same level. Two lines tied at one level must resolve to the lower number, which catches a reversed scan. Nested entry and return are checked level by level, so a design that retires the wrong active bit or forgets the outer level shows a wrong `cur_level`. The threshold is checked at its exact boundary, and the bench confirms it has no effect on the non-maskable source. A level write to an enabled line is followed by arbitration that would flip if the write had landed, and a table base with stray low bits shows whether alignment is enforced.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

    localparam int SYS_SRCS  = 3;
    localparam int SRC_NMI   = 0;
    localparam int SRC_FAULT = 1;
    localparam int SRC_TICK  = 2;

    localparam logic [7:0] EXC_NMI      = 8'd2;
    localparam logic [7:0] EXC_FAULT    = 8'd3;
    localparam logic [7:0] EXC_TICK     = 8'd15;
    localparam logic [7:0] EXC_IRQ_BASE = 8'd16;

    typedef logic [7:0] level_t;
    localparam level_t LVL_NMI       = 8'd0;
    localparam level_t LVL_FAULT     = 8'd1;
    localparam level_t LVL_PROG_BASE = 8'd2;
    localparam level_t LVL_IDLE      = 8'hFF;

    typedef enum logic [3:0] {
        REG_EN_SET    = 4'd0,
        REG_EN_CLR    = 4'd1,
        REG_PEND_SET  = 4'd2,
        REG_PEND_CLR  = 4'd3,
        REG_ACTIVE    = 4'd4,
        REG_PRIO      = 4'd6,
        REG_VTBASE    = 4'd7,
        REG_MASKLVL   = 4'd8,
        REG_TICK_PRIO = 4'd9
    } reg_sel_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] src;
        level_t     lvl;
    } pick_t;

    // Map an internal source slot to its architectural exception number.
    function automatic logic [7:0] exc_of_src(input logic [7:0] src);
        case (src)
            8'd0:    return EXC_NMI;
            8'd1:    return EXC_FAULT;
            8'd2:    return EXC_TICK;
            default: return src + (EXC_IRQ_BASE - 8'(SYS_SRCS));
        endcase
    endfunction

    // Programmable 2-bit value lifted above the two fixed system levels.
    function automatic level_t prog_level(input logic [7:0] raw);
        return raw + LVL_PROG_BASE;
    endfunction

endpackage

// File: rtl/arb_pend_bank.sv
`timescale 1ns/1ps
module arb_pend_bank #(
    parameter int NSRC = 35
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_lines,
    input  logic [NSRC-1:0] sw_set,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] take_clr,
    output logic [NSRC-1:0] pend
);
    logic [NSRC-1:0] prev_q;
    logic [NSRC-1:0] rise;

    assign rise = req_lines & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= req_lines;
            // a fresh event in the same cycle as a clear is kept
            pend   <= (pend & ~(sw_clr | take_clr)) | rise | sw_set;
        end
    end
endmodule

// File: rtl/arb_cfg_regs.sv
`timescale 1ns/1ps
module arb_cfg_regs
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    parameter int ADDR_W  = 32
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           wr_en,
    input  reg_sel_e                       wr_sel,
    input  logic [31:0]                    wdata,
    output logic [NUM_IRQ-1:0]             irq_en,
    output logic [NUM_IRQ-1:0][PRIO_W-1:0] irq_lvl,
    output logic [PRIO_W-1:0]              tick_lvl,
    output logic [PRIO_W-1:0]              mask_lvl,
    output logic [ADDR_W-1:0]              tbl_base,
    output logic [NUM_IRQ-1:0]             sw_pend_set,
    output logic [NUM_IRQ-1:0]             sw_pend_clr
);
    localparam int ALIGN_BITS = 7;

    logic wr_prio;
    assign wr_prio = wr_en && (wr_sel == REG_PRIO);

    assign sw_pend_set = (wr_en && wr_sel == REG_PEND_SET) ? wdata[NUM_IRQ-1:0] : '0;
    assign sw_pend_clr = (wr_en && wr_sel == REG_PEND_CLR) ? wdata[NUM_IRQ-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_en <= '0;
        end else if (wr_en && wr_sel == REG_EN_SET) begin
            irq_en <= irq_en | wdata[NUM_IRQ-1:0];
        end else if (wr_en && wr_sel == REG_EN_CLR) begin
            irq_en <= irq_en & ~wdata[NUM_IRQ-1:0];
        end
    end

    // level of an enabled line is frozen; writes to it are dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_lvl <= '0;
        end else begin
            for (int i = 0; i < NUM_IRQ; i++) begin
                if (wr_prio && wdata[15:8] == 8'(i) && !irq_en[i]) begin
                    irq_lvl[i] <= wdata[PRIO_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_lvl <= '0;
            mask_lvl <= '0;
            tbl_base <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                REG_TICK_PRIO: tick_lvl <= wdata[PRIO_W-1:0];
                REG_MASKLVL:   mask_lvl <= wdata[PRIO_W-1:0];
                REG_VTBASE:    tbl_base <= {wdata[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/arb_pick.sv
`timescale 1ns/1ps
module arb_pick
    import irq_arb_pkg::*;
#(
    parameter int NSRC = 35
) (
    input  logic [NSRC-1:0]        cand,
    input  logic [NSRC-1:0][7:0]   lvl,
    output pick_t                  best
);
    // strict compare keeps the lowest slot on a tie
    always_comb begin
        best     = '0;
        best.lvl = LVL_IDLE;
        for (int i = 0; i < NSRC; i++) begin
            if (cand[i] && (!best.vld || lvl[i] < best.lvl)) begin
                best.vld = 1'b1;
                best.src = 8'(i);
                best.lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/arb_active.sv
`timescale 1ns/1ps
module arb_active #(
    parameter int NSRC = 35
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_vld,
    input  logic [7:0]      set_src,
    input  logic            clr_vld,
    input  logic [7:0]      clr_src,
    output logic [NSRC-1:0] active
);
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] clr_vec;

    always_comb begin
        set_vec = '0;
        clr_vec = '0;
        for (int i = 0; i < NSRC; i++) begin
            set_vec[i] = set_vld && (set_src == 8'(i));
            clr_vec[i] = clr_vld && (clr_src == 8'(i));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else begin
            active <= (active & ~clr_vec) | set_vec;
        end
    end
endmodule

// File: rtl/irq_prio_arbiter.sv
`timescale 1ns/1ps
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic               nmi_req,
    input  logic               fault_req,
    input  logic               tick_req,
    input  logic               reg_wr,
    input  logic [3:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               take_valid,
    output logic [7:0]         take_excnum,
    output logic [ADDR_W-1:0]  take_vector,
    input  logic               take_ack,
    input  logic               ret_req,
    output logic [7:0]         cur_level
);
    localparam int NSRC = NUM_IRQ + SYS_SRCS;

    reg_sel_e                       sel;
    logic [NUM_IRQ-1:0]             irq_en;
    logic [NUM_IRQ-1:0][PRIO_W-1:0] irq_lvl;
    logic [PRIO_W-1:0]              tick_lvl;
    logic [PRIO_W-1:0]              mask_lvl;
    logic [ADDR_W-1:0]              tbl_base;
    logic [NUM_IRQ-1:0]             sw_pend_set;
    logic [NUM_IRQ-1:0]             sw_pend_clr;

    logic [NSRC-1:0]      lines_all;
    logic [NSRC-1:0]      en_all;
    logic [NSRC-1:0]      mask_ok;
    logic [NSRC-1:0]      pend;
    logic [NSRC-1:0]      active;
    logic [NSRC-1:0]      elig;
    logic [NSRC-1:0]      take_clr;
    logic [NSRC-1:0][7:0] lvl_all;
    pick_t                pick_pend;
    pick_t                pick_act;
    level_t               take_level;
    level_t               mask_thr;
    logic                 fire;
    logic                 retire;

    assign sel = reg_sel_e'(reg_addr);

    arb_cfg_regs #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .ADDR_W  (ADDR_W)
    ) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (reg_wr),
        .wr_sel      (sel),
        .wdata       (reg_wdata),
        .irq_en      (irq_en),
        .irq_lvl     (irq_lvl),
        .tick_lvl    (tick_lvl),
        .mask_lvl    (mask_lvl),
        .tbl_base    (tbl_base),
        .sw_pend_set (sw_pend_set),
        .sw_pend_clr (sw_pend_clr)
    );

    assign lines_all = {irq_lines, tick_req, fault_req, nmi_req};
    assign en_all    = {irq_en, {SYS_SRCS{1'b1}}};
    assign mask_thr  = prog_level(8'(mask_lvl));

    // fixed system levels, then programmable ones
    assign lvl_all[SRC_NMI]   = LVL_NMI;
    assign lvl_all[SRC_FAULT] = LVL_FAULT;
    assign lvl_all[SRC_TICK]  = prog_level(8'(tick_lvl));
    assign mask_ok[SRC_NMI]   = 1'b1;
    assign mask_ok[SRC_FAULT] = 1'b1;
    assign mask_ok[SRC_TICK]  = (mask_lvl == '0) || (lvl_all[SRC_TICK] < mask_thr);

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
        assign lvl_all[SYS_SRCS+g] = prog_level(8'(irq_lvl[g]));
        assign mask_ok[SYS_SRCS+g] = (mask_lvl == '0) || (lvl_all[SYS_SRCS+g] < mask_thr);
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_clr
        assign take_clr[g] = fire && (pick_pend.src == 8'(g));
    end

    arb_pend_bank #(.NSRC(NSRC)) u_pend (
        .clk       (clk),
        .rst       (rst),
        .req_lines (lines_all),
        .sw_set    ({sw_pend_set, {SYS_SRCS{1'b0}}}),
        .sw_clr    ({sw_pend_clr, {SYS_SRCS{1'b0}}}),
        .take_clr  (take_clr),
        .pend      (pend)
    );

    assign elig = pend & en_all & mask_ok;

    arb_pick #(.NSRC(NSRC)) u_pick_pend (
        .cand (elig),
        .lvl  (lvl_all),
        .best (pick_pend)
    );

    arb_pick #(.NSRC(NSRC)) u_pick_act (
        .cand (active),
        .lvl  (lvl_all),
        .best (pick_act)
    );

    assign cur_level   = pick_act.vld ? pick_act.lvl : LVL_IDLE;
    assign take_level  = pick_pend.lvl;
    assign take_valid  = pick_pend.vld && (pick_pend.lvl < cur_level);
    assign take_excnum = exc_of_src(pick_pend.src);
    assign take_vector = tbl_base + ADDR_W'({take_excnum, 2'b00});
    assign fire        = take_valid && take_ack;
    assign retire      = ret_req && pick_act.vld;

    arb_active #(.NSRC(NSRC)) u_active (
        .clk     (clk),
        .rst     (rst),
        .set_vld (fire),
        .set_src (pick_pend.src),
        .clr_vld (retire),
        .clr_src (pick_act.src),
        .active  (active)
    );

    always_comb begin
        case (sel)
            REG_EN_SET:    reg_rdata = 32'(irq_en);
            REG_PEND_SET:  reg_rdata = 32'(pend[NSRC-1:SYS_SRCS]);
            REG_ACTIVE:    reg_rdata = 32'(active[NSRC-1:SYS_SRCS]);
            REG_VTBASE:    reg_rdata = 32'(tbl_base);
            REG_MASKLVL:   reg_rdata = 32'(mask_lvl);
            REG_TICK_PRIO: reg_rdata = 32'(tick_lvl);
            default:       reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_prio_arbiter_chk.sv
`timescale 1ns/1ps
module irq_prio_arbiter_chk #(
    parameter int NSRC   = 35,
    parameter int PRIO_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              take_valid,
    input logic              take_ack,
    input logic              ret_req,
    input logic [7:0]        take_excnum,
    input logic [7:0]        take_level,
    input logic [7:0]        cur_level,
    input logic [PRIO_W-1:0] mask_lvl,
    input logic [NSRC-1:0]   active
);
    // R1
    take_above_cur_chk: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> take_level < cur_level);

    // R10
    nest_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_ack && !ret_req) |=> cur_level == $past(take_level));

    // R10
    ret_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !(take_valid && take_ack) && active != '0)
        |=> $countones(active) == $countones($past(active)) - 1);

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && mask_lvl != '0 && take_level >= 8'd2)
        |-> take_level < 8'(mask_lvl) + 8'd2);

    // R4
    excnum_range_chk: assert property (@(posedge clk) disable iff (rst)
        take_valid |-> (take_excnum == 8'd2 || take_excnum == 8'd3 ||
                        take_excnum == 8'd15 || take_excnum >= 8'd16));

    // R3
    sys_first_chk: assert property (@(posedge clk) disable iff (rst)
        (take_valid && take_excnum == 8'd2) |-> take_level == 8'd0);
endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
    .NSRC   (NSRC),
    .PRIO_W (PRIO_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .take_valid  (take_valid),
    .take_ack    (take_ack),
    .ret_req     (ret_req),
    .take_excnum (take_excnum),
    .take_level  (take_level),
    .cur_level   (cur_level),
    .mask_lvl    (mask_lvl),
    .active      (active)
);

// File: tb/irq_prio_arbiter_bench.sv
`timescale 1ns/1ps
module irq_prio_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] irq_lines;
    logic        nmi_req, fault_req, tick_req;
    logic        reg_wr;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        take_valid;
    logic [7:0]  take_excnum;
    logic [31:0] take_vector;
    logic        take_ack, ret_req;
    logic [7:0]  cur_level;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .nmi_req(nmi_req),
        .fault_req(fault_req), .tick_req(tick_req), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .take_valid(take_valid), .take_excnum(take_excnum),
        .take_vector(take_vector), .take_ack(take_ack), .ret_req(ret_req),
        .cur_level(cur_level)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        irq_lines = '0; nmi_req = 0; fault_req = 0; tick_req = 0;
        reg_wr = 0; reg_addr = '0; reg_wdata = '0; take_ack = 0; ret_req = 0;
        rst = 1;
        step(); step();
        rst = 0;
        step();
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic accept();
        take_ack = 1;
        step();
        take_ack = 0;
    endtask

    task automatic retn();
        ret_req = 1;
        step();
        ret_req = 0;
    endtask

    task automatic setup_irq(input int n, input int lvl);
        wr(4'd6, (32'(n) << 8) | 32'(lvl));
        wr(4'd0, 32'd1 << n);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R11 take_valid", 32'(take_valid), 0);
        check("R11 cur_level", 32'(cur_level), 255);
        rd(4'd0, d); check("R11 enables", d, 0);
        rd(4'd7, d); check("R11 base", d, 0);
        rd(4'd8, d); check("R11 threshold", d, 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        do_reset();
        setup_irq(5, 2);
        irq_lines[5] = 1; step();
        check("R9 edge offers", 32'(take_valid), 1);
        check("R4 excnum irq5", 32'(take_excnum), 21);
        check("R5 vector irq5", take_vector, 32'h54);
        rd(4'd2, d); check("R9 pend bit", d, 32'h20);
        accept();
        check("R10 level after take", 32'(cur_level), 4);
        check("R1 no re-offer", 32'(take_valid), 0);
        rd(4'd2, d); check("R9 pend cleared on take", d, 0);
        rd(4'd4, d); check("R10 active bit", d, 32'h20);
        retn();
        check("R10 idle after return", 32'(cur_level), 255);
        rd(4'd4, d); check("R10 active cleared", d, 0);
    endtask

    task automatic t_order();
        do_reset();
        setup_irq(3, 1); setup_irq(7, 1); setup_irq(12, 0);
        irq_lines[3] = 1; irq_lines[7] = 1; step();
        check("R2 tie lower number", 32'(take_excnum), 19);
        irq_lines[12] = 1; step();
        check("R2 lower value wins", 32'(take_excnum), 28);
    endtask

    task automatic t_nest();
        do_reset();
        setup_irq(4, 2); setup_irq(6, 1); setup_irq(8, 2);
        irq_lines[4] = 1; step();
        accept();
        check("R10 outer level", 32'(cur_level), 4);
        irq_lines[8] = 1; step();
        check("R1 equal level waits", 32'(take_valid), 0);
        irq_lines[6] = 1; step();
        check("R1 higher preempts", 32'(take_valid), 1);
        check("R4 excnum irq6", 32'(take_excnum), 22);
        accept();
        check("R10 nested level", 32'(cur_level), 3);
        retn();
        check("R10 restore outer", 32'(cur_level), 4);
        check("R1 equal still waits", 32'(take_valid), 0);
        retn();
        check("R10 idle", 32'(cur_level), 255);
        check("R9 waiting one offered", 32'(take_excnum), 24);
    endtask

    task automatic t_sys();
        do_reset();
        wr(4'd9, 32'd0);
        setup_irq(0, 0);
        nmi_req = 1; fault_req = 1; tick_req = 1; irq_lines[0] = 1; step();
        check("R3 nmi first", 32'(take_excnum), 2);
        check("R5 nmi vector", take_vector, 32'h8);
        accept();
        check("R3 nmi level", 32'(cur_level), 0);
        check("R3 fault below nmi", 32'(take_valid), 0);
        retn();
        check("R4 fault excnum", 32'(take_excnum), 3);
        check("R5 fault vector", take_vector, 32'hC);
        accept();
        check("R3 fault level", 32'(cur_level), 1);
        retn();
        check("R2 tick wins tie", 32'(take_excnum), 15);
        check("R5 tick vector", take_vector, 32'h3C);
    endtask

    task automatic t_mask();
        do_reset();
        setup_irq(2, 2); setup_irq(9, 1);
        wr(4'd8, 32'd2);
        irq_lines[2] = 1; step();
        check("R7 threshold holds equal", 32'(take_valid), 0);
        irq_lines[9] = 1; step();
        check("R7 above threshold passes", 32'(take_excnum), 25);
        accept(); retn();
        check("R7 still held", 32'(take_valid), 0);
        nmi_req = 1; step();
        check("R7 nmi not masked", 32'(take_excnum), 2);
        accept(); retn();
        wr(4'd8, 32'd0);
        check("R7 zero disables", 32'(take_valid), 1);
        check("R7 released excnum", 32'(take_excnum), 18);
    endtask

    task automatic t_ignore();
        do_reset();
        setup_irq(10, 0); setup_irq(1, 1);
        wr(4'd6, (32'd10 << 8) | 32'd3);
        irq_lines[10] = 1; irq_lines[1] = 1; step();
        check("R8 enabled write ignored", 32'(take_excnum), 26);
        wr(4'd1, 32'd1 << 10);
        wr(4'd6, (32'd10 << 8) | 32'd3);
        wr(4'd0, 32'd1 << 10);
        check("R8 disabled write lands", 32'(take_excnum), 17);
    endtask

    task automatic t_base();
        logic [31:0] d;
        do_reset();
        wr(4'd7, 32'h2000_00FF);
        rd(4'd7, d); check("R6 aligned base", d, 32'h2000_0080);
        setup_irq(31, 0);
        irq_lines[31] = 1; step();
        check("R4 excnum irq31", 32'(take_excnum), 47);
        check("R5 relocated vector", take_vector, 32'h2000_013C);
    endtask

    task automatic t_swpend();
        logic [31:0] d;
        do_reset();
        wr(4'd6, (32'd13 << 8) | 32'd1);
        wr(4'd2, 32'd1 << 13);
        check("R9 disabled not offered", 32'(take_valid), 0);
        rd(4'd2, d); check("R9 sw pend set", d, 32'h2000);
        wr(4'd0, 32'd1 << 13);
        check("R9 enable offers", 32'(take_excnum), 29);
        wr(4'd3, 32'd1 << 13);
        check("R9 clear withdraws", 32'(take_valid), 0);
        rd(4'd2, d); check("R9 pend cleared", d, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_order();
        t_nest();
        t_sys();
        t_mask();
        t_ignore();
        t_base();
        t_swpend();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule